// File: doc/BRIEF.md
# Serial-bus memory read target

This block is a two-wire serial bus target (I2C) that gives a controller read access to a byte-wide memory of 2^ADDR_W locations, 16K by default. The memory sits beside the block and is reached through a synchronous read port: the block presents an address, and the data is expected one system clock later. The block keeps a byte pointer that survives from one transaction to the next. A read header returns the byte under the pointer. A write header followed by two address bytes reloads the pointer, so a repeated START with a read header turns the sequence into a random read. When the controller acknowledges a byte, the block keeps streaming bytes from the following addresses.

Both bus lines are sampled through synchronizer flops clocked by the system clock, which must run at least eight times faster than SCL. START and STOP are detected on the synchronized lines. The block pulls SDA low through an open-drain enable for its acknowledge bits and for the zero bits of its read data. It never drives SDA high.

Top module: `i2c_eeprom_rd_target`

## Requirements
- R1: While reset is asserted, and directly after it, sda_oe is 0 and the byte pointer (mem_addr) is 0. A read header as the first transaction returns the byte at address 0.
- R2: A header whose upper four bits are 1010 and whose next three bits equal strap_addr is acknowledged by pulling SDA low in the ninth clock. Any other header gets no acknowledge. After such a header, SDA stays released until the next START, and the pointer is left unchanged.
- R3: After a read header (bit 0 = 1) is acknowledged, the byte at the pointer is driven MSB first. Its first bit is valid during the first SCL high period after the acknowledge.
- R4: A write header (bit 0 = 0) followed by two acknowledged address bytes loads the pointer with {first[ADDR_W-9:0], second}. The upper bits of the first byte are ignored. A repeated START and read header then return the byte at that address.
- R5: An ACK from the controller (SDA low in the ninth clock) makes the block send the byte at the next address. After a NoACK and then a STOP, the block is idle with SDA released, and mem_addr holds the address after the last byte sent, so the next current-address read continues from there.
- R6: The pointer wraps from the last location (0x3FFF by default) to 0x0000 during a sequential read. It does not stop or wrap at any page boundary.
- R7: A START or STOP seen in the middle of a byte abandons that byte. After a START, a new header is received from its first bit, and the pointer is not changed.
- R8: The block changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_addr | input | 3 | Selectable low bits of the 7-bit target address |
| mem_addr | output | ADDR_W | Byte pointer, used as the memory read address |
| mem_rdata | input | 8 | Memory data for mem_addr, one clock after it |

## Verification
The bench targets five corner cases:
- Pointer wrap at the top of memory, and reads that cross a 0x2000 boundary. A page-wrapping or saturating counter returns the wrong byte after the top location.
- Address bytes with the upper two bits set. A design that keeps those bits reads from an address that does not exist.
- Headers with a wrong strap value or a wrong fixed prefix. A sloppy comparator acknowledges them, or drives data onto a bus that belongs to another target.
- START and STOP in the middle of a byte. A design that does not clear its bit count on them misframes the next header and never acknowledges it.
- Current-address reads after a STOP. A design that fails to keep or advance its pointer returns the wrong byte.

// File: rtl/i2c_eeprom_pkg.sv
`timescale 1ns/1ps
package i2c_eeprom_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_HDR_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_SKIP
   } rd_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int MSB = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] scl_p;
   logic [MSB:0] sda_p;
   logic         scl_d;
   logic         sda_d;
   logic         scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_p <= {scl_p[MSB-1:0], scl_in};
         sda_p <= {sda_p[MSB-1:0], sda_in};
         scl_d <= scl_p[MSB];
         sda_d <= sda_p[MSB];
      end
   end

   assign scl_s     = scl_p[MSB];
   assign sda_s     = sda_p[MSB];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_addr_ctr.sv
`timescale 1ns/1ps
module i2c_addr_ctr #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (inc) begin
         q <= q + W'(1);
      end
   end

endmodule

// File: rtl/i2c_rd_engine.sv
`timescale 1ns/1ps
module i2c_rd_engine
   import i2c_eeprom_pkg::*;
#(
   parameter int         ADDR_W   = 14,
   parameter int         STRAP_W  = 3,
   parameter int         PREFIX_W = 4,
   parameter logic [3:0] PREFIX   = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [STRAP_W-1:0] strap,
   input  logic [BYTE_W-1:0] rdata,
   output logic              sda_oe,
   output logic              ctr_ld,
   output logic              ctr_inc,
   output logic [ADDR_W-1:0] ld_val,
   output rd_state_e         state_o
);

   localparam int HI_W = ADDR_W - BYTE_W;

   rd_state_e         state_q;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [HI_W-1:0]   ahi_q;
   logic              got_ack;
   logic              rx_state;
   logic              byte_done;
   logic              hdr_match;

   assign rx_state  = (state_q == ST_HDR) || (state_q == ST_AHI) || (state_q == ST_ALO);
   assign byte_done = rx_state && scl_fall && (bit_cnt == 4'd8);
   assign hdr_match = (rx_sh[7:1] == {PREFIX[PREFIX_W-1:0], strap});

   always_comb begin
      ctr_ld  = (state_q == ST_ALO) && byte_done;
      ld_val  = {ahi_q, rx_sh};
      ctr_inc = ((state_q == ST_HDR_ACK) && scl_fall && rx_sh[0]) ||
                ((state_q == ST_TX_ACK) && scl_fall && got_ack);
   end

   always_comb begin
      sda_oe = 1'b0;
      if ((state_q == ST_HDR_ACK) || (state_q == ST_AHI_ACK) || (state_q == ST_ALO_ACK)) begin
         sda_oe = 1'b1;
      end else if (state_q == ST_TX) begin
         sda_oe = ~tx_sh[7];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         ahi_q   <= '0;
         got_ack <= 1'b0;
      end else if (start_det) begin
         state_q <= ST_HDR;
         bit_cnt <= '0;
      end else if (stop_det) begin
         state_q <= ST_IDLE;
         bit_cnt <= '0;
      end else begin
         case (state_q)
            ST_HDR, ST_AHI, ST_ALO: begin
               if (scl_rise && (bit_cnt < 4'd8)) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               if (byte_done) begin
                  bit_cnt <= '0;
                  if (state_q == ST_HDR) begin
                     state_q <= hdr_match ? ST_HDR_ACK : ST_SKIP;
                  end else if (state_q == ST_AHI) begin
                     ahi_q   <= rx_sh[HI_W-1:0];
                     state_q <= ST_AHI_ACK;
                  end else begin
                     state_q <= ST_ALO_ACK;
                  end
               end
            end
            ST_HDR_ACK: begin
               if (scl_fall) begin
                  if (rx_sh[0]) begin
                     tx_sh   <= rdata;
                     bit_cnt <= '0;
                     state_q <= ST_TX;
                  end else begin
                     state_q <= ST_AHI;
                  end
               end
            end
            ST_AHI_ACK: begin
               if (scl_fall) state_q <= ST_ALO;
            end
            ST_ALO_ACK: begin
               if (scl_fall) state_q <= ST_SKIP;
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     got_ack <= 1'b0;
                     state_q <= ST_TX_ACK;
                  end else begin
                     tx_sh   <= {tx_sh[6:0], 1'b0};
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) got_ack <= ~sda_s;
               if (scl_fall) begin
                  if (got_ack) begin
                     tx_sh   <= rdata;
                     state_q <= ST_TX;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/i2c_eeprom_rd_target.sv
`timescale 1ns/1ps
module i2c_eeprom_rd_target
   import i2c_eeprom_pkg::*;
#(
   parameter int         ADDR_W      = 14,
   parameter int         STRAP_W     = 3,
   parameter int         PREFIX_W    = 4,
   parameter logic [3:0] PREFIX      = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                sda_oe,
   input  logic [STRAP_W-1:0]  strap_addr,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic [BYTE_W-1:0]   mem_rdata
);

   generate
      if ((ADDR_W < 9) || (ADDR_W > 16)) begin : g_bad_addr
         $error("i2c_eeprom_rd_target: ADDR_W must be 9..16");
      end
      if ((PREFIX_W + STRAP_W) != 7) begin : g_bad_tgt
         $error("i2c_eeprom_rd_target: prefix and strap must form 7 bits");
      end
   endgenerate

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              ctr_ld;
   logic              ctr_inc;
   logic [ADDR_W-1:0] ld_val;
   rd_state_e         eng_state;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_rd_engine #(
      .ADDR_W   (ADDR_W),
      .STRAP_W  (STRAP_W),
      .PREFIX_W (PREFIX_W),
      .PREFIX   (PREFIX)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap     (strap_addr),
      .rdata     (mem_rdata),
      .sda_oe    (sda_oe),
      .ctr_ld    (ctr_ld),
      .ctr_inc   (ctr_inc),
      .ld_val    (ld_val),
      .state_o   (eng_state)
   );

   i2c_addr_ctr #(.W(ADDR_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ctr_ld),
      .ld_val (ld_val),
      .inc    (ctr_inc),
      .q      (mem_addr)
   );

endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
`timescale 1ns/1ps
module i2c_eeprom_rd_chk
   import i2c_eeprom_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_in,
   input logic              sda_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              ctr_ld,
   input logic              stop_det,
   input rd_state_e         state
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!sda_oe && (mem_addr == '0)));

   // R8
   drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_in);

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(mem_addr) && !$past(ctr_ld)) |->
         (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R5
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE));

   // R5
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R2
   skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

endmodule

bind i2c_eeprom_rd_target i2c_eeprom_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_in   (scl_in),
   .sda_oe   (sda_oe),
   .mem_addr (mem_addr),
   .ctr_ld   (ctr_ld),
   .stop_det (stop_det),
   .state    (eng_state)
);

// File: tb/i2c_eeprom_rd_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_rd_target_tb;

   localparam int AW = 14;
   localparam int Q  = 5;
   localparam int NV = 6;

   // {random flag, raw 16-bit address sent, byte count}
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 16'h0123, 4'd1},
      {1'b0, 16'h0000, 4'd2},
      {1'b1, 16'h3FFE, 4'd4},
      {1'b0, 16'h0000, 4'd1},
      {1'b1, 16'hC005, 4'd2},
      {1'b1, 16'h1FFF, 4'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          sda_m = 1'b1;
   logic          sda_line;
   logic          sda_oe;
   logic [2:0]    strap = 3'b011;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata;
   int            checks = 0;
   int            fails = 0;
   int            r8_viol = 0;
   logic          done = 1'b0;
   logic          oe_prev = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
      return a[7:0] ^ {a[13:8], 2'b10} ^ 8'h5A;
   endfunction

   always_ff @(posedge clk) mem_rdata <= mem_f(mem_addr);

   i2c_eeprom_rd_target u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (scl),
      .sda_in     (sda_line),
      .sda_oe     (sda_oe),
      .strap_addr (strap),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata)
   );

   // R8 monitor: sda_oe must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && scl && (sda_oe !== oe_prev)) r8_viol++;
      oe_prev <= sda_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
   endtask

   task automatic write_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int k = 7; k >= 0; k--) send_bit(v[k]);
      recv_bit(a);
      acked = ~a;
   endtask

   task automatic read_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int k = 7; k >= 0; k--) begin
         recv_bit(b);
         v[k] = b;
      end
      send_bit(~give_ack);
   endtask

   initial begin : main
      logic          ack;
      logic [7:0]    v;
      logic [AW-1:0] ptr;
      ptr = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 sda_oe in reset", sda_oe, 1'b0);
      check("R1 pointer in reset", mem_addr, '0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 pointer after reset", mem_addr, '0);
      bus_start();
      write_byte({4'b1010, strap, 1'b1}, ack);
      check("R2 read header ack", ack, 1'b1);
      read_byte(v, 1'b0);
      check("R1 first read at 0", v, mem_f(ptr));
      ptr = ptr + 1'b1;
      bus_stop();

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic        rnd;
         logic [15:0] raw;
         logic [3:0]  n;
         {rnd, raw, n} = VEC[i];
         if (rnd) begin
            bus_start();
            write_byte({4'b1010, strap, 1'b0}, ack);
            check("R2 write header ack", ack, 1'b1);
            write_byte(raw[15:8], ack);
            check("R4 address hi ack", ack, 1'b1);
            write_byte(raw[7:0], ack);
            check("R4 address lo ack", ack, 1'b1);
            ptr = raw[AW-1:0];
         end
         bus_start();
         write_byte({4'b1010, strap, 1'b1}, ack);
         check("R3 read header ack", ack, 1'b1);
         for (int j = 0; j < int'(n); j++) begin
            read_byte(v, j != int'(n) - 1);
            if (j == 0) check(rnd ? "R4 random byte" : "R3 current byte", v, mem_f(ptr));
            else if (ptr == '0) check("R6 wrapped byte", v, mem_f(ptr));
            else check("R5 sequential byte", v, mem_f(ptr));
            ptr = ptr + 1'b1;
         end
         bus_stop();
         repeat (4) @(negedge clk);
         check("R5 idle release", sda_oe, 1'b0);
         check("R5 pointer after read", mem_addr, ptr);
      end

      // R2: wrong strap, then wrong prefix
      bus_start();
      write_byte({4'b1010, ~strap, 1'b1}, ack);
      check("R2 wrong strap nack", ack, 1'b0);
      read_byte(v, 1'b0);
      check("R2 bus left released", v, 8'hFF);
      bus_start();
      write_byte({4'b1011, strap, 1'b1}, ack);
      check("R2 wrong prefix nack", ack, 1'b0);
      bus_stop();
      repeat (4) @(negedge clk);
      check("R2 pointer kept", mem_addr, ptr);

      // R2: a new strap value is matched
      strap = 3'b110;
      bus_start();
      write_byte({4'b1010, strap, 1'b1}, ack);
      check("R2 new strap ack", ack, 1'b1);
      read_byte(v, 1'b0);
      check("R3 byte after strap change", v, mem_f(ptr));
      ptr = ptr + 1'b1;
      bus_stop();

      // R7: START inside a byte
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      bus_start();
      write_byte({4'b1010, strap, 1'b1}, ack);
      check("R7 header after restart", ack, 1'b1);
      read_byte(v, 1'b0);
      check("R7 byte after restart", v, mem_f(ptr));
      ptr = ptr + 1'b1;
      bus_stop();

      // R7: STOP inside an address byte
      bus_start();
      write_byte({4'b1010, strap, 1'b0}, ack);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      repeat (4) @(negedge clk);
      check("R7 pointer after stop abort", mem_addr, ptr);
      check("R7 released after stop abort", sda_oe, 1'b0);

      check("R8 sda_oe moved while SCL high", r8_viol, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule